// File: doc/BRIEF.md
# Priority Pin-Multiplexed GPIO Port

This block is an eight-pin general-purpose I/O port. On-chip peripherals can take its pins away from software in a fixed order. The pins form two groups of four. Each group may be claimed first by a stall-detect unit and then by a motor-control PWM pair. Software keeps the group only when both of those peripherals are disabled. Software reaches the port through a small register bus with three registers: a data register, a direction register and a per-pin slew-limit register.

The data register reads back differently depending on each pin's mode. An output pin returns the stored bit. An input pin with slew limiting enabled returns a constant 1. An input pin without slew limiting returns the pin level after a two-flop synchronizer. Ownership is decided combinationally, so a peripheral takes or gives up a group in the same cycle its enable changes. Writes to the data register are always accepted, even while a peripheral owns the pins.

Top module: `pmx_port`

## Requirements
- R1: When `sd_en[1]` is 1, `pin_out[7:4]` equals `sd_out[7:4]` and `pin_oe[7:4]` equals `sd_oe[7:4]`, whatever `mc_en[1]` is.
- R2: When `sd_en[0]` is 1, `pin_out[3:0]` equals `sd_out[3:0]` and `pin_oe[3:0]` equals `sd_oe[3:0]`, whatever `mc_en[0]` is.
- R3: When a group's `sd_en` bit is 0 and its `mc_en` bit is 1, that group's `pin_out` and `pin_oe` equal the group's slices of `mc_out` and `mc_oe` (group 1 is bits 7:4, group 0 is bits 3:0).
- R4: When a group's `sd_en` and `mc_en` bits are both 0, that group's `pin_out` equals the data register bits and its `pin_oe` equals the direction register bits.
- R5: While `rst_n` is 0, `pin_oe` is 0x00. After reset the data, direction and slew registers read 0x00.
- R6: A write (`bus_wr`=1) takes effect at the next rising clock edge. Offset 0x40 is the data register, 0x42 the direction register and 0x43 the slew register. Direction and slew read back as stored. Any other offset reads 0x00, and a write to it changes nothing.
- R7: Reading offset 0x40, a bit whose direction bit is 1 returns the stored data bit.
- R8: Reading offset 0x40, a bit whose direction bit is 0 and whose slew bit is 1 returns 1.
- R9: Reading offset 0x40, a bit whose direction bit is 0 and whose slew bit is 0 returns the `pin_in` level sampled two rising edges earlier.
- R10: A data-register write made while a peripheral owns the pins is kept. It appears on `pin_out` as soon as the group returns to GPIO control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| sd_en | input | 2 | Stall-detect enable per group (bit 1 = pins 7:4) |
| sd_out | input | 8 | Stall-detect pin values |
| sd_oe | input | 8 | Stall-detect output enables |
| mc_en | input | 2 | PWM pair enable per group |
| mc_out | input | 8 | PWM pin values |
| mc_oe | input | 8 | PWM output enables |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables (1 = drive) |

## Verification
The assertions assume that `pin_in` and all peripheral inputs are synchronous to `clk` and free of X after reset. The read-latency property also assumes that `bus_addr` stays within 8 bits and that at least two edges have passed since reset. The stimulus changes every input only on the falling edge and keeps each one at a defined value from time zero. Reset is asserted at the start and once more in the middle of the run. Random enables cover all four owner combinations for both groups.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PORT_W = 8;
  localparam int GRP_W  = 4;
  localparam int GRP_N  = PORT_W / GRP_W;

  typedef enum logic [1:0] {
    OWN_GPIO  = 2'd0,
    OWN_PWM   = 2'd1,
    OWN_STALL = 2'd2
  } owner_e;

  // Fixed priority: stall detect, then PWM pair, then software.
  function automatic owner_e pick_owner(input logic stall_on, input logic pwm_on);
    if (stall_on)    return OWN_STALL;
    else if (pwm_on) return OWN_PWM;
    else             return OWN_GPIO;
  endfunction

  // Per-bit read-back of the data register.
  function automatic logic [PORT_W-1:0] data_readback(
    input logic [PORT_W-1:0] stored,
    input logic [PORT_W-1:0] dir,
    input logic [PORT_W-1:0] slew,
    input logic [PORT_W-1:0] pins
  );
    return (dir & stored) | (~dir & slew) | (~dir & ~slew & pins);
  endfunction
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs
  import pmx_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADR_DATA = 'h40,
  parameter logic [ADDR_W-1:0] ADR_DIR  = 'h42,
  parameter logic [ADDR_W-1:0] ADR_SLEW = 'h43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pins_sync,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] slew_q
);
  logic hit_data, hit_dir, hit_slew;
  assign hit_data = (addr == ADR_DATA);
  assign hit_dir  = (addr == ADR_DIR);
  assign hit_slew = (addr == ADR_SLEW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      slew_q <= '0;
    end else if (wr) begin
      if (hit_data) data_q <= wdata;
      if (hit_dir)  dir_q  <= wdata;
      if (hit_slew) slew_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_data)      rdata = data_readback(data_q, dir_q, slew_q, pins_sync);
    else if (hit_dir)  rdata = dir_q;
    else if (hit_slew) rdata = slew_q;
  end

  // R6: a write to the data offset is stored at the next edge
  a_r6_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_data) |=> (data_q == $past(wdata)));
  // R6: a write to the direction offset is stored at the next edge
  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_dir) |=> (dir_q == $past(wdata)));
  // R6: registers hold when no write targets them
  a_r6_slew_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_slew) |=> $stable(slew_q));
endmodule

// File: rtl/pmx_group_arb.sv
module pmx_group_arb
  import pmx_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic          stall_on,
  input  logic [GW-1:0] stall_out,
  input  logic [GW-1:0] stall_oe,
  input  logic          pwm_on,
  input  logic [GW-1:0] pwm_out,
  input  logic [GW-1:0] pwm_oe,
  input  logic [GW-1:0] gp_out,
  input  logic [GW-1:0] gp_oe,
  output owner_e        owner,
  output logic [GW-1:0] grp_out,
  output logic [GW-1:0] grp_oe
);
  assign owner = pick_owner(stall_on, pwm_on);

  always_comb begin
    unique case (owner)
      OWN_STALL: begin grp_out = stall_out; grp_oe = stall_oe; end
      OWN_PWM:   begin grp_out = pwm_out;   grp_oe = pwm_oe;   end
      default:   begin grp_out = gp_out;    grp_oe = gp_oe;    end
    endcase
  end
endmodule

// File: rtl/pmx_port.sv
module pmx_port
  import pmx_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADR_DATA = 'h40,
  parameter logic [ADDR_W-1:0] ADR_DIR  = 'h42,
  parameter logic [ADDR_W-1:0] ADR_SLEW = 'h43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [GRP_N-1:0]  sd_en,
  input  logic [PORT_W-1:0] sd_out,
  input  logic [PORT_W-1:0] sd_oe,
  input  logic [GRP_N-1:0]  mc_en,
  input  logic [PORT_W-1:0] mc_out,
  input  logic [PORT_W-1:0] mc_oe,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] pins_sync;
  logic [PORT_W-1:0] data_q, dir_q, slew_q;
  logic [PORT_W-1:0] arb_out, arb_oe;
  owner_e            grp_owner [GRP_N];

  pmx_sync #(.W(PORT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  pmx_regs #(
    .ADDR_W(ADDR_W), .ADR_DATA(ADR_DATA), .ADR_DIR(ADR_DIR), .ADR_SLEW(ADR_SLEW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pins_sync(pins_sync), .rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q), .slew_q(slew_q)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    pmx_group_arb #(.GW(GRP_W)) u_arb (
      .stall_on (sd_en[g]),
      .stall_out(sd_out[g*GRP_W +: GRP_W]),
      .stall_oe (sd_oe[g*GRP_W +: GRP_W]),
      .pwm_on   (mc_en[g]),
      .pwm_out  (mc_out[g*GRP_W +: GRP_W]),
      .pwm_oe   (mc_oe[g*GRP_W +: GRP_W]),
      .gp_out   (data_q[g*GRP_W +: GRP_W]),
      .gp_oe    (dir_q[g*GRP_W +: GRP_W]),
      .owner    (grp_owner[g]),
      .grp_out  (arb_out[g*GRP_W +: GRP_W]),
      .grp_oe   (arb_oe[g*GRP_W +: GRP_W])
    );

    // R1/R2: an enabled stall-detect unit drives the group
    a_r1_stall_owns: assert property (@(posedge clk) disable iff (!rst_n)
      sd_en[g] |-> (pin_out[g*GRP_W +: GRP_W] == sd_out[g*GRP_W +: GRP_W]) &&
                   (pin_oe[g*GRP_W +: GRP_W]  == sd_oe[g*GRP_W +: GRP_W]));
    // R3: PWM pair drives when the stall unit is off
    a_r3_pwm_owns: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_en[g] && mc_en[g]) |->
        (pin_out[g*GRP_W +: GRP_W] == mc_out[g*GRP_W +: GRP_W]) &&
        (pin_oe[g*GRP_W +: GRP_W]  == mc_oe[g*GRP_W +: GRP_W]));
    // R4: software registers drive when both peripherals are off
    a_r4_gpio_owns: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_en[g] && !mc_en[g]) |->
        (pin_oe[g*GRP_W +: GRP_W] == dir_q[g*GRP_W +: GRP_W]) &&
        (pin_out[g*GRP_W +: GRP_W] == data_q[g*GRP_W +: GRP_W]));
  end

  assign pin_out = arb_out;
  assign pin_oe  = rst_n ? arb_oe : '0;

  // Edges seen since reset release, saturating at two.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R5: no pin is driven while reset is held
  a_r5_reset_hiz: assert property (@(posedge clk) !rst_n |-> (pin_oe == '0));
  // R9: plain input bits return the pin level from two edges back
  a_r9_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && bus_addr == ADR_DATA) |->
      ((bus_rdata & ~dir_q & ~slew_q) == ($past(pin_in, 2) & ~dir_q & ~slew_q)));
  // R8: slew-limited input bits read as 1
  a_r8_slew_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_DATA) |-> ((bus_rdata & ~dir_q & slew_q) == (~dir_q & slew_q)));
endmodule

// File: tb/sim_pmx_port.sv
module sim_pmx_port;
  localparam int W = 8;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [1:0]   sd_en = 2'b00, mc_en = 2'b00;
  logic [W-1:0] sd_out = '0, sd_oe = '0, mc_out = '0, mc_oe = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;

  pmx_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sd_en(sd_en), .sd_out(sd_out), .sd_oe(sd_oe),
    .mc_en(mc_en), .mc_out(mc_out), .mc_oe(mc_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // Reference state
  logic [W-1:0] m_data, m_dir, m_slew;
  logic [W-1:0] hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= '0; m_dir <= '0; m_slew <= '0;
      hist = {8'h00, 8'h00};
    end else begin
      hist.push_back(pin_in);
      void'(hist.pop_front());
      if (bus_wr) begin
        if (bus_addr == 8'h40) m_data <= bus_wdata;
        if (bus_addr == 8'h42) m_dir  <= bus_wdata;
        if (bus_addr == 8'h43) m_slew <= bus_wdata;
      end
    end
  end

  task automatic check8(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [3:0] eo, eoe;
    string tag;
    logic [W-1:0] synced;
    synced = hist[0];
    for (int g = 0; g < 2; g++) begin
      if (sd_en[g]) begin
        eo = sd_out[g*4 +: 4]; eoe = sd_oe[g*4 +: 4]; tag = (g == 1) ? "R1" : "R2";
      end else if (mc_en[g]) begin
        eo = mc_out[g*4 +: 4]; eoe = mc_oe[g*4 +: 4]; tag = "R3";
      end else begin
        eo = m_data[g*4 +: 4]; eoe = m_dir[g*4 +: 4]; tag = "R4";
      end
      if (!rst_n) check8("R5", {4'h0, pin_oe[g*4 +: 4]}, 8'h00);
      else begin
        check8(tag, {4'h0, pin_out[g*4 +: 4]}, {4'h0, eo});
        check8(tag, {4'h0, pin_oe[g*4 +: 4]}, {4'h0, eoe});
      end
    end
    case (bus_addr)
      8'h40: begin
        check8("R7", bus_rdata & m_dir, m_data & m_dir);
        check8("R8", bus_rdata & ~m_dir & m_slew, ~m_dir & m_slew);
        check8("R9", bus_rdata & ~m_dir & ~m_slew, synced & ~m_dir & ~m_slew);
      end
      8'h42:   check8("R6", bus_rdata, m_dir);
      8'h43:   check8("R6", bus_rdata, m_slew);
      default: check8("R6", bus_rdata, 8'h00);
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom_range(0, 5))
      0, 1:    return 8'h40;
      2:       return 8'h42;
      3:       return 8'h43;
      4:       return 8'h41;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  task automatic randomize_inputs();
    bus_wr    = ($urandom_range(0, 2) == 0);
    bus_addr  = pick_addr();
    bus_wdata = 8'($urandom);
    sd_en     = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
    mc_en     = 2'($urandom);
    sd_out    = 8'($urandom); sd_oe = 8'($urandom);
    mc_out    = 8'($urandom); mc_oe = 8'($urandom);
    pin_in    = 8'($urandom);
  endtask

  initial begin
    // R5: hold reset, pins must be undriven
    sd_en = 2'b11; sd_oe = 8'hFF; mc_en = 2'b11; mc_oe = 8'hFF;
    repeat (3) step();
    sd_en = 2'b00; mc_en = 2'b00; sd_oe = '0; mc_oe = '0;
    rst_n = 1'b1;
    bus_addr = 8'h42; step(); check8("R5", bus_rdata, 8'h00);
    bus_addr = 8'h43; step(); check8("R5", bus_rdata, 8'h00);
    bus_addr = 8'h40; step(); check8("R5", bus_rdata, 8'h00);
    check8("R5", pin_oe, 8'h00);

    // R10: data written while stall units own both groups
    sd_en = 2'b11; bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 8'h5A; step();
    bus_addr = 8'h42; bus_wdata = 8'hFF; step();
    bus_wr = 1'b0; sd_en = 2'b00; mc_en = 2'b00; step();
    check8("R10", pin_out, 8'h5A);
    check8("R10", pin_oe, 8'hFF);

    // R8 / R9: inputs with mixed slew
    bus_wr = 1'b1; bus_addr = 8'h42; bus_wdata = 8'h0F; step();
    bus_addr = 8'h43; bus_wdata = 8'h30; step();
    bus_wr = 1'b0; bus_addr = 8'h40; pin_in = 8'hC3; step();
    step(); step();
    check8("R9", bus_rdata, 8'hF0 & 8'hC3 | 8'h30 | (8'h0F & 8'h5A));

    for (int i = 0; i < CYCLES; i++) begin
      randomize_inputs();
      if (i == CYCLES / 2) rst_n = 1'b0;
      if (i == CYCLES / 2 + 3) rst_n = 1'b1;
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule